// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Read Engine

This block is the addressing and read half of a byte-wide serial memory that sits on a two-wire bus as a slave. It oversamples the clock line and the data line with the system clock, picks out start and stop conditions, and answers only to its own device address. The fixed part of that address is `1010 0`; the next two bits come from strap pins, so four such devices can share one bus. After the address it takes a two-byte word address and then serves reads from a computed, read-only array of `2**ADDR_W` bytes (8K by default).

Three kinds of read are served. A current-address read uses the internal counter. A random read is a dummy write of the word address, then a repeated start, then a read. A sequential read continues either of these for as long as the master acknowledges each byte. The counter wraps at the top of the array. Word address `0xFFFF` is special: it returns a register byte supplied from outside, and the engine goes idle after that one byte. A dummy write that ends in a stop only loads the counter. Data bytes written after the word address are acknowledged and passed to a neighbouring block through a one-cycle report, with the counter stepping as it does for reads.

The engine never drives the bus high. It only pulls the data line low, for acknowledge bits and for zero data bits, and it changes that pull only while the clock line is low.

Top module: `serial_mem_reader`

## Requirements
- R1: The address byte is `1010 0`, then the two strap bits (upper first), then the direction bit (1 = read). When the upper seven bits match, the engine pulls the data line low during the ninth clock of that byte.
- R2: When the upper seven bits do not match, the engine does not acknowledge, drives nothing, and ignores the bus until the next start.
- R3: In a random read (write-direction address byte, word address high byte, low byte, repeated start, read-direction address byte), the first data byte is the array byte at the loaded address. Array byte at index i is `i[7:0] XOR {i[12:8], 3'b101}`.
- R4: A stop right after the word address loads the counter and does nothing else. The next current-address read returns the byte at that address.
- R5: A stop after only the high word-address byte leaves the counter unchanged. The word address is committed only when the low byte is complete.
- R6: Each byte sent advances the counter by one. A master acknowledge after a data byte makes the engine send the next byte. A later current-address read starts one past the last byte sent.
- R7: The counter wraps from `2**ADDR_W - 1` to 0. Word-address bits at and above `ADDR_W` do not select array bytes, except in R8.
- R8: With the counter at `0xFFFF`, a read returns `reg_byte`. The counter stays at `0xFFFF`, and after that single byte the engine goes idle and releases the line, even if the master acknowledges.
- R9: Read data leaves most significant bit first, and the data-line pull changes only while the clock line is low.
- R10: After a master no-acknowledge the engine releases the line and sends nothing more until the next start.
- R11: In write direction, each data byte after the word address is acknowledged. Each one gives a one-cycle `wr_hook_valid` with the counter value and the byte, and the counter then advances as in R6 and R7.
- R12: A stop returns the engine to idle. Bytes clocked after it without a start get no acknowledge and no data.
- R13: Out of reset the engine drives nothing, reports no write, and waits for a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| strap_sel | input | 2 | Strap pins giving the low two device-address bits |
| reg_byte | input | 8 | Register byte returned for word address 0xFFFF |
| sda_pull | output | 1 | 1 = pull the data line low |
| wr_hook_valid | output | 1 | One-cycle pulse per received write data byte |
| wr_hook_addr | output | 16 | Counter value the written byte is meant for |
| wr_hook_data | output | 8 | Received write data byte |

## Verification
The bench builds the engine with `ADDR_W = 8`, a 256-byte array, and strap value `2'b10`. With this small array, one sequential read can sweep every byte and carry on past the wrap at 0xFF. Word addresses such as 0x1234, whose high bits lie outside the array, show that those bits are ignored. The bench also sweeps all 128 values of the seven-bit device address against the straps. In further cases it interrupts the word address after its high byte, reads the register address with a master acknowledge, and sends write data across the wrap point to exercise the write report.

// File: rtl/serial_mem_pkg.sv
// Package: shared state encoding, constants and the array content
// function for the two-wire serial memory read engine.
package serial_mem_pkg;

    // Word address that selects the externally supplied register byte.
    localparam logic [15:0] REG_ADDR = 16'hFFFF;

    // Fixed upper part of the seven-bit device address.
    localparam logic [6:0] DEV_ID = 7'b1010000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WHI,
        ST_WHI_ACK,
        ST_WLO,
        ST_WLO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK
    } eng_state_t;

    // Content of the read-only array model at a given index.
    function automatic logic [7:0] pattern_byte(input logic [12:0] idx);
        return idx[7:0] ^ {idx[12:8], 3'b101};
    endfunction

endpackage

// File: rtl/bus_cond_detect.sv
// Module: bus_cond_detect
// Synchronises the two bus lines into the clk domain and flags clock
// edges plus start and stop conditions, one cycle each.
// Assumes clk is at least several times faster than the bus clock and
// that both lines idle high.
module bus_cond_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] scl_sh;
    logic [SH_W-1:0] sda_sh;
    logic            scl_prev;
    logic            sda_prev;

    // Shift both lines through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[SH_W-2:0], scl_in};
            sda_sh <= {sda_sh[SH_W-2:0], sda_in};
        end
    end

    // Decode edges and bus conditions from settled and previous levels.
    always_comb begin
        scl_lvl   = scl_sh[SYNC_STAGES-1];
        sda_lvl   = sda_sh[SYNC_STAGES-1];
        scl_prev  = scl_sh[SYNC_STAGES];
        sda_prev  = sda_sh[SYNC_STAGES];
        scl_rise  = scl_lvl && !scl_prev;
        scl_fall  = !scl_lvl && scl_prev;
        start_det = scl_lvl && scl_prev && sda_prev && !sda_lvl;
        stop_det  = scl_lvl && scl_prev && !sda_prev && sda_lvl;
    end

endmodule

// File: rtl/mem_pattern_rom.sv
// Module: mem_pattern_rom
// Read-only array model: returns the byte at the counter's index, or
// the register byte when the counter holds the register address.
// Assumes ADDR_W is 13 or less; index bits above ADDR_W are dropped.
module mem_pattern_rom
    import serial_mem_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [15:0] rd_addr,
    input  logic [7:0]  reg_byte,
    output logic [7:0]  rd_data,
    output logic        rd_is_reg
);
    localparam logic [15:0] IDX_MASK = 16'((32'd1 << ADDR_W) - 32'd1);

    logic [15:0] idx;

    // Select between the register byte and the computed array byte.
    always_comb begin
        idx       = rd_addr & IDX_MASK;
        rd_is_reg = (rd_addr == REG_ADDR);
        rd_data   = rd_is_reg ? reg_byte : pattern_byte(idx[12:0]);
    end

endmodule

// File: rtl/mem_read_fsm.sv
// Module: mem_read_fsm
// Byte-level protocol engine: device address match, two-byte word
// address, read data shifting, master acknowledge handling and the
// write report. It acts on clock edges from bus_cond_detect.
// Assumes fetch_data/fetch_is_reg reflect the current ptr combinationally.
module mem_read_fsm
    import serial_mem_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int STRAP_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_lvl,
    input  logic               sda_lvl,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic [STRAP_W-1:0] strap,
    input  logic [7:0]         fetch_data,
    input  logic               fetch_is_reg,
    output logic [15:0]        ptr,
    output logic               sda_pull,
    output logic               hook_valid,
    output logic [15:0]        hook_addr,
    output logic [7:0]         hook_data
);
    localparam logic [15:0] WRAP_MASK = 16'((32'd1 << ADDR_W) - 32'd1);

    eng_state_t  state;
    logic [3:0]  bit_cnt;
    logic [7:0]  rx;
    logic [7:0]  tx;
    logic        tx_reg;
    logic [7:0]  hi_tmp;
    logic        rw_rd;
    logic        m_ack;
    logic        addr_hit;

    // Counter step: hold at the register address, otherwise wrap.
    function automatic logic [15:0] step_ptr(input logic [15:0] p);
        return (p == REG_ADDR) ? p : ((p + 16'd1) & WRAP_MASK);
    endfunction

    // Compare the received address byte with the fixed id and straps.
    always_comb begin
        addr_hit = (rx[7:STRAP_W+1] == DEV_ID[6:STRAP_W]) && (rx[STRAP_W:1] == strap);
    end

    // Protocol state, shifting, counter and line pull.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            rx         <= '0;
            tx         <= '0;
            tx_reg     <= 1'b0;
            hi_tmp     <= '0;
            rw_rd      <= 1'b0;
            m_ack      <= 1'b0;
            ptr        <= '0;
            sda_pull   <= 1'b0;
            hook_valid <= 1'b0;
            hook_addr  <= '0;
            hook_data  <= '0;
        end else begin
            hook_valid <= 1'b0;
            if (stop_det) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else if (start_det) begin
                state    <= ST_DEV;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEV, ST_WHI, ST_WLO, ST_WDAT: begin
                        if (scl_rise) begin
                            rx      <= {rx[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (state == ST_DEV) begin
                                if (addr_hit) begin
                                    rw_rd    <= rx[0];
                                    sda_pull <= 1'b1;
                                    state    <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_WHI) begin
                                hi_tmp   <= rx;
                                sda_pull <= 1'b1;
                                state    <= ST_WHI_ACK;
                            end else if (state == ST_WLO) begin
                                ptr      <= {hi_tmp, rx};
                                sda_pull <= 1'b1;
                                state    <= ST_WLO_ACK;
                            end else begin
                                hook_valid <= 1'b1;
                                hook_addr  <= ptr;
                                hook_data  <= rx;
                                ptr        <= step_ptr(ptr);
                                sda_pull   <= 1'b1;
                                state      <= ST_WDAT_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK, ST_WHI_ACK, ST_WLO_ACK, ST_WDAT_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (state == ST_DEV_ACK && rw_rd) begin
                                tx       <= fetch_data;
                                tx_reg   <= fetch_is_reg;
                                sda_pull <= ~fetch_data[7];
                                ptr      <= step_ptr(ptr);
                                state    <= ST_RDAT;
                            end else begin
                                sda_pull <= 1'b0;
                                if (state == ST_DEV_ACK)      state <= ST_WHI;
                                else if (state == ST_WHI_ACK) state <= ST_WLO;
                                else                          state <= ST_WDAT;
                            end
                        end
                    end
                    ST_RDAT: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_pull <= 1'b0;
                                bit_cnt  <= '0;
                                state    <= tx_reg ? ST_IDLE : ST_RACK;
                            end else begin
                                tx       <= {tx[6:0], 1'b0};
                                sda_pull <= ~tx[6];
                                bit_cnt  <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            bit_cnt <= '0;
                            if (m_ack) begin
                                tx       <= fetch_data;
                                tx_reg   <= fetch_is_reg;
                                sda_pull <= ~fetch_data[7];
                                ptr      <= step_ptr(ptr);
                                state    <= ST_RDAT;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        // Idle: only a start (handled above) has any effect.
                    end
                endcase
            end
        end
    end

    // R9: the pull moves only while the synchronised clock line is low.
    assert_pull_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) && !$past(start_det) && !$past(stop_det)
        |-> !$past(scl_lvl));

    // R2: a mismatching address byte leaves the engine idle and silent.
    assert_mismatch_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV) && scl_fall && (bit_cnt == 4'd8) && !addr_hit
        |=> (state == ST_IDLE) && !sda_pull);

    // R8: the register byte is the only byte of its transfer.
    assert_reg_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDAT) && tx_reg && scl_fall && (bit_cnt == 4'd7)
        && !start_det && !stop_det
        |=> (state == ST_IDLE) && !sda_pull);

    // R12: a stop always leaves the engine idle with the line released.
    assert_stop_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE) && !sda_pull);

endmodule

// File: rtl/serial_mem_reader.sv
// Module: serial_mem_reader (top)
// Two-wire serial memory slave read engine: line conditioning,
// protocol engine and computed array model.
// Assumes an external open-drain data line driven low when sda_pull=1.
module serial_mem_reader #(
    parameter int ADDR_W      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_in,
    input  logic        sda_in,
    input  logic [1:0]  strap_sel,
    input  logic [7:0]  reg_byte,
    output logic        sda_pull,
    output logic        wr_hook_valid,
    output logic [15:0] wr_hook_addr,
    output logic [7:0]  wr_hook_data
);
    logic        scl_lvl;
    logic        sda_lvl;
    logic        scl_rise;
    logic        scl_fall;
    logic        start_det;
    logic        stop_det;
    logic [15:0] ptr;
    logic [7:0]  fetch_data;
    logic        fetch_is_reg;

    bus_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    mem_pattern_rom #(.ADDR_W(ADDR_W)) u_rom (
        .rd_addr   (ptr),
        .reg_byte  (reg_byte),
        .rd_data   (fetch_data),
        .rd_is_reg (fetch_is_reg)
    );

    mem_read_fsm #(.ADDR_W(ADDR_W), .STRAP_W(2)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_lvl      (scl_lvl),
        .sda_lvl      (sda_lvl),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .strap        (strap_sel),
        .fetch_data   (fetch_data),
        .fetch_is_reg (fetch_is_reg),
        .ptr          (ptr),
        .sda_pull     (sda_pull),
        .hook_valid   (wr_hook_valid),
        .hook_addr    (wr_hook_addr),
        .hook_data    (wr_hook_data)
    );

    // R11: each write report is a single-cycle pulse.
    assert_hook_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hook_valid |=> !wr_hook_valid);

endmodule

// File: tb/sim_serial_mem_reader.sv
// Bench: bus-level master model against a 256-byte build of the engine.
module sim_serial_mem_reader;
    localparam int          CLK_PERIOD = 10;
    localparam int          Q          = 5;
    localparam int          AW         = 8;
    localparam logic [1:0]  STRAP      = 2'b10;
    localparam int          WATCHDOG   = 195000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [7:0]  reg_val = 8'hC3;
    logic        sda_pull;
    logic        hook_valid;
    logic [15:0] hook_addr;
    logic [7:0]  hook_data;
    logic        sda_w;

    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [15:0] cap_a [0:7];
    logic [7:0]  cap_d [0:7];
    int          cap_n = 0;

    assign sda_w = m_sda & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_mem_reader #(.ADDR_W(AW)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (m_scl),
        .sda_in        (sda_w),
        .strap_sel     (STRAP),
        .reg_byte      (reg_val),
        .sda_pull      (sda_pull),
        .wr_hook_valid (hook_valid),
        .wr_hook_addr  (hook_addr),
        .wr_hook_data  (hook_data)
    );

    // Capture write reports away from the active edge.
    always @(negedge clk) begin
        if (rst_n && hook_valid && cap_n < 8) begin
            cap_a[cap_n] = hook_addr;
            cap_d[cap_n] = hook_data;
            cap_n = cap_n + 1;
        end
    end

    function automatic logic [7:0] exp_byte(input int unsigned idx);
        logic [12:0] i;
        i = 13'(idx);
        return i[7:0] ^ {i[12:8], 3'b101};
    endfunction

    function automatic logic [7:0] dev(input logic rw);
        return {5'b10100, STRAP, rw};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_cond();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic stop_cond();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = sda_w; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(x);
        acked = (x == 1'b0);
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(x);
            v[i] = x;
        end
        send_bit(~mack);
    endtask

    // Dummy write of a full word address; leaves the bus after the low byte.
    task automatic load_addr(input logic [15:0] a);
        logic ak;
        start_cond();
        send_byte(dev(1'b0), ak);
        send_byte(a[15:8], ak);
        send_byte(a[7:0], ak);
        chk("R3 word address ack", {31'd0, ak}, 32'd1);
    endtask

    // Current-address read of one byte ending in no-acknowledge and stop.
    task automatic cur_read(output logic [7:0] v);
        logic ak;
        start_cond();
        send_byte(dev(1'b1), ak);
        recv_byte(v, 1'b0);
        stop_cond();
    endtask

    initial begin
        logic        ak;
        logic [7:0]  d;

        tick(5);
        // R13: state out of reset
        chk("R13 pull after reset", {31'd0, sda_pull}, 32'd0);
        chk("R13 hook after reset", {31'd0, hook_valid}, 32'd0);
        rst_n = 1'b1;
        tick(5);

        // R1 / R2: sweep every seven-bit device address in write direction
        for (int v = 0; v < 128; v++) begin
            start_cond();
            send_byte({7'(v), 1'b0}, ak);
            stop_cond();
            chk((v == {5'b10100, STRAP}) ? "R1 matching address ack" : "R2 foreign address no ack",
                {31'd0, ak}, (v == {5'b10100, STRAP}) ? 32'd1 : 32'd0);
        end

        // R2: foreign read address sends no data
        start_cond();
        send_byte({5'b10100, 2'b01, 1'b1}, ak);
        chk("R2 foreign read no ack", {31'd0, ak}, 32'd0);
        recv_byte(d, 1'b0);
        chk("R2 foreign read line idle", {24'd0, d}, 32'hFF);
        stop_cond();

        // R3 / R7: random reads, including high bits outside the array
        begin
            logic [15:0] alist [5] = '{16'h0000, 16'h0037, 16'h00A5, 16'h00FF, 16'h1234};
            for (int k = 0; k < 5; k++) begin
                load_addr(alist[k]);
                start_cond();
                send_byte(dev(1'b1), ak);
                chk("R3 read address ack", {31'd0, ak}, 32'd1);
                recv_byte(d, 1'b0);
                stop_cond();
                chk("R3 R7 random read byte", {24'd0, d}, {24'd0, exp_byte(alist[k] & 16'h00FF)});
            end
        end

        // R4 / R6: set current address, then two current reads
        load_addr(16'h0042);
        stop_cond();
        cur_read(d);
        chk("R4 read after set address", {24'd0, d}, {24'd0, exp_byte(16'h42)});
        cur_read(d);
        chk("R6 counter advanced", {24'd0, d}, {24'd0, exp_byte(16'h43)});

        // R5: stop after the high byte alone keeps the counter
        load_addr(16'h00FF);
        stop_cond();
        start_cond();
        send_byte(dev(1'b0), ak);
        send_byte(8'hFF, ak);
        stop_cond();
        cur_read(d);
        chk("R5 partial word address ignored", {24'd0, d}, {24'd0, exp_byte(16'hFF)});

        // R6 / R7 / R9: full sequential sweep across the wrap
        load_addr(16'h0000);
        start_cond();
        send_byte(dev(1'b1), ak);
        for (int k = 0; k < 259; k++) begin
            recv_byte(d, (k != 258));
            chk("R6 R7 R9 sequential byte", {24'd0, d}, {24'd0, exp_byte(k % 256)});
        end
        // R10: nothing follows a no-acknowledge
        recv_byte(d, 1'b1);
        chk("R10 line released after nack", {24'd0, d}, 32'hFF);
        stop_cond();
        cur_read(d);
        chk("R6 counter after sweep", {24'd0, d}, {24'd0, exp_byte(3)});

        // R8: register address, one byte then idle
        load_addr(16'hFFFF);
        start_cond();
        send_byte(dev(1'b1), ak);
        recv_byte(d, 1'b1);
        chk("R8 register byte", {24'd0, d}, 32'hC3);
        recv_byte(d, 1'b1);
        chk("R8 idle after register byte", {24'd0, d}, 32'hFF);
        stop_cond();
        reg_val = 8'h5A;
        cur_read(d);
        chk("R8 counter holds register address", {24'd0, d}, 32'h5A);

        // R11 / R7: write report across the wrap
        cap_n = 0;
        load_addr(16'h00FE);
        send_byte(8'h11, ak);
        chk("R11 data ack", {31'd0, ak}, 32'd1);
        send_byte(8'h22, ak);
        send_byte(8'h33, ak);
        stop_cond();
        chk("R11 report count", 32'(cap_n), 32'd3);
        chk("R11 first addr", {16'd0, cap_a[0]}, 32'h00FE);
        chk("R11 first data", {24'd0, cap_d[0]}, 32'h11);
        chk("R11 second addr", {16'd0, cap_a[1]}, 32'h00FF);
        chk("R11 second data", {24'd0, cap_d[1]}, 32'h22);
        chk("R11 R7 wrapped addr", {16'd0, cap_a[2]}, 32'h0000);
        chk("R11 third data", {24'd0, cap_d[2]}, 32'h33);

        // R12: bytes without a start after stop are ignored
        send_byte(dev(1'b1), ak);
        chk("R12 no ack without start", {31'd0, ak}, 32'd0);
        recv_byte(d, 1'b0);
        chk("R12 no data without start", {24'd0, d}, 32'hFF);
        stop_cond();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks = n_checks + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule